// File: doc/BRIEF.md
# Receive Monitor Descriptor Builder

The block turns receive-side MPDU events into eight-word status descriptors for a monitor ring. Each accepted event carries four opaque frame-info words, two status-buffer address words and a handful of per-frame fields: push reason, error code, fragment number and a frameless block-ack-request flag. From these the block forms one descriptor. It sends the descriptor out over a valid/ready stream as eight 32-bit beats, word 0 first. Word 6 packs the per-frame fields together with a running count of status buffers used in the current PPDU. Word 7 carries the PHY PPDU counter value captured at PPDU start. The ring-placement fields in word 7 are left at zero, to be stamped by a later stage.

When configured to, the block also emits a separate PPDU-closing marker descriptor on a PPDU end or flush indication. In the marker the end-of-PPDU bit is set and every MPDU-level field is zero. A push reason of 3 is illegal. Such an event is consumed and dropped, and a one-cycle flag is raised.

Top module: `mon_desc_builder`

## Requirements
- R1: Word 6 of an MPDU descriptor holds push reason in [1:0], error code in [6:2], fragment number in [10:7], the frameless flag in [11], status count in [15:12] and 0 in the end-of-PPDU bit [16]. Bits [31:17] are always zero.
- R2: Word 7 holds the PPDU id in [15:0]. Bits [31:16] (a zero field plus ring id and loop count for a downstream stamper) are zero.
- R3: Push reason codes are 0 for error, 1 for routing and 2 for flush. An event with code 3 is accepted and produces no descriptor. `illegalPush` is high for exactly the cycle after acceptance.
- R4: The error code is passed through only when the push reason is 0. Otherwise word 6 [6:2] is zero.
- R5: The fragment number is emitted only when bit 20 of the emitted word 2 is set. Otherwise it is zero.
- R6: When the frameless flag is set, words 0 and 1 are zero, word 2 keeps only bits [19:8] and bit 23 (mask 0x008FFF00), word 3 passes unchanged, and bit 11 of word 6 is 1.
- R7: Otherwise words 0–3 equal `evtFrameInfo` words 0–3 (word i at bits [32i+31:32i]), and words 4–5 equal `evtStatAddr` low and high.
- R8: While `outValid` is high and `outReady` is low, `outData` and `outValid` stay unchanged. `outLast` marks the eighth beat.
- R9: `evtReady` is low from the accepting edge until the eighth beat has transferred, and while a marker is pending.
- R10: With `cfgEndMarkEn` set, a pulse on `ppduEnd` or `ppduFlush` queues a marker. The marker is sent before any further event: words 0–3 zero, words 4–5 = `endStatAddr`, push reason 2 for flush (flush wins) or 1 for end, error, fragment and frameless fields zero, bit 16 set, and count and id as at the end pulse. With `cfgEndMarkEn` clear, no marker appears.
- R11: The status count rises by one per `statBufUsed` pulse, saturates at 15 and is cleared by `ppduStart`. A descriptor carries the count held before its accepting edge.
- R12: The id loaded by `ppduStart` appears in word 7 [15:0] when `cfgCopyPpduId` is set. Otherwise that field is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgEndMarkEn | input | 1 | Enable PPDU-closing marker descriptors |
| cfgCopyPpduId | input | 1 | Copy the captured PPDU id into word 7 |
| evtValid | input | 1 | MPDU event present |
| evtReady | output | 1 | Event accepted when high with evtValid |
| evtFrameInfo | input | 128 | Frame-info words 0–3 |
| evtStatAddr | input | 64 | Status-buffer address words 4–5 |
| evtPushReason | input | 2 | Push reason code |
| evtErrCode | input | 5 | Error code |
| evtFragNum | input | 4 | Fragment number |
| evtFramelessBar | input | 1 | Frameless block-ack-request info |
| statBufUsed | input | 1 | One status buffer consumed |
| ppduStart | input | 1 | PPDU start pulse |
| ppduId | input | 16 | PHY PPDU counter sampled at ppduStart |
| ppduEnd | input | 1 | PPDU end pulse |
| ppduFlush | input | 1 | Flush pulse |
| endStatAddr | input | 64 | Status address for the marker, sampled with end/flush |
| outValid | output | 1 | Descriptor beat valid |
| outReady | input | 1 | Downstream accepts the beat |
| outData | output | 32 | Descriptor word |
| outLast | output | 1 | Final word of a descriptor |
| illegalPush | output | 1 | Event with push reason 3 was dropped |

## Verification
The bench targets the field-forcing rules. One test drives an error code with a non-error push reason, so a design that forwards the code unconditionally shows a non-zero [6:2]. Another drives a set fragment flag under a frameless event, so a design that tests the raw input flag instead of the masked word emits a fragment number. An all-ones frameless frame exposes any mask that keeps the wrong bits of word 2 or leaves words 0 and 1 alone. Further tests push the status count past 15 to catch wrap-around, close PPDUs with both end and flush to catch swapped marker codes, send a code-3 event to catch a descriptor leaking out, and stall the stream to catch a beat that advances or changes under back-pressure.

// File: rtl/mdb_pkg.sv
package mdb_pkg;
  localparam int WORD_W   = 32;
  localparam int N_WORDS  = 8;
  localparam int IDX_W    = $clog2(N_WORDS);
  localparam int CNT_W    = 4;
  localparam int ID_W     = 16;
  localparam int FRAG_W   = 4;
  localparam int ERR_W    = 5;
  localparam int FRAME_W  = 4 * WORD_W;
  localparam int ADDR_W   = 2 * WORD_W;
  localparam logic [1:0] PUSH_ERR   = 2'd0;
  localparam logic [1:0] PUSH_ROUTE = 2'd1;
  localparam logic [1:0] PUSH_FLUSH = 2'd2;
  localparam logic [1:0] PUSH_BAD   = 2'd3;
  localparam logic [WORD_W-1:0] FRAMELESS_KEEP = 32'h008F_FF00;
  localparam int FRAG_FLAG_BIT = 20;

  typedef struct packed {
    logic             loadEvt;
    logic             loadMark;
    logic             advance;
    logic [IDX_W-1:0] wordSel;
  } mdb_strobe_t;
endpackage

// File: rtl/mdb_ctrl.sv
module mdb_ctrl
  import mdb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgEndMarkEn,
  input  logic        evtValid,
  input  logic [1:0]  evtPushReason,
  input  logic        ppduEnd,
  input  logic        ppduFlush,
  input  logic        outReady,
  output logic        evtReady,
  output logic        outValid,
  output logic        outLast,
  output logic        illegalPush,
  output mdb_strobe_t stb
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WORDS - 1);

  logic             sending;
  logic [IDX_W-1:0] wordIdx;
  logic             markPending;
  logic             illegalQ;
  logic             takeEvt;

  always_comb begin
    evtReady     = !sending && !markPending;
    takeEvt      = evtReady && evtValid;
    stb.loadEvt  = takeEvt && (evtPushReason != PUSH_BAD);
    stb.loadMark = !sending && markPending;
    stb.advance  = sending && outReady;
    stb.wordSel  = wordIdx;
    outValid     = sending;
    outLast      = sending && (wordIdx == LAST_IDX);
    illegalPush  = illegalQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sending     <= 1'b0;
      wordIdx     <= '0;
      markPending <= 1'b0;
      illegalQ    <= 1'b0;
    end else begin
      if (stb.loadEvt || stb.loadMark) begin
        sending <= 1'b1;
        wordIdx <= '0;
      end else if (stb.advance) begin
        if (wordIdx == LAST_IDX) sending <= 1'b0;
        wordIdx <= wordIdx + 1'b1;
      end
      markPending <= (markPending && !stb.loadMark) ||
                     (cfgEndMarkEn && (ppduEnd || ppduFlush));
      illegalQ    <= takeEvt && (evtPushReason == PUSH_BAD);
    end
  end
endmodule

// File: rtl/mdb_datapath.sv
module mdb_datapath
  import mdb_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgCopyPpduId,
  input  logic [FRAME_W-1:0] evtFrameInfo,
  input  logic [ADDR_W-1:0]  evtStatAddr,
  input  logic [1:0]         evtPushReason,
  input  logic [ERR_W-1:0]   evtErrCode,
  input  logic [FRAG_W-1:0]  evtFragNum,
  input  logic               evtFramelessBar,
  input  logic               statBufUsed,
  input  logic               ppduStart,
  input  logic [ID_W-1:0]    ppduId,
  input  logic               ppduEnd,
  input  logic               ppduFlush,
  input  logic [ADDR_W-1:0]  endStatAddr,
  input  mdb_strobe_t        stb,
  output logic [WORD_W-1:0]  outData
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [N_WORDS-1:0][WORD_W-1:0] descQ;
  logic [N_WORDS-1:0][WORD_W-1:0] evtDesc;
  logic [N_WORDS-1:0][WORD_W-1:0] markDesc;
  logic [CNT_W-1:0]  statCnt;
  logic [ID_W-1:0]   curId;
  logic [CNT_W-1:0]  markCnt;
  logic [ID_W-1:0]   markId;
  logic [ADDR_W-1:0] markAddr;
  logic              markFlush;
  logic [3:0][WORD_W-1:0] frameW;
  logic [FRAG_W-1:0] fragOut;
  logic [ERR_W-1:0]  errOut;
  logic [ID_W-1:0]   idOut;
  logic [ID_W-1:0]   markIdOut;

  // frame-info words, with the frameless mask applied
  genvar gi;
  generate
    for (gi = 0; gi < 4; gi++) begin : g_frame
      logic [WORD_W-1:0] rawW;
      assign rawW = evtFrameInfo[gi*WORD_W +: WORD_W];
      if (gi < 2) begin : g_clear
        assign frameW[gi] = evtFramelessBar ? '0 : rawW;
      end else if (gi == 2) begin : g_mask
        assign frameW[gi] = evtFramelessBar ? (rawW & FRAMELESS_KEEP) : rawW;
      end else begin : g_keep
        assign frameW[gi] = rawW;
      end
    end
  endgenerate

  always_comb begin
    fragOut   = frameW[2][FRAG_FLAG_BIT] ? evtFragNum : '0;
    errOut    = (evtPushReason == PUSH_ERR) ? evtErrCode : '0;
    idOut     = cfgCopyPpduId ? curId : '0;
    markIdOut = cfgCopyPpduId ? markId : '0;

    evtDesc[0] = frameW[0];
    evtDesc[1] = frameW[1];
    evtDesc[2] = frameW[2];
    evtDesc[3] = frameW[3];
    evtDesc[4] = evtStatAddr[WORD_W-1:0];
    evtDesc[5] = evtStatAddr[ADDR_W-1:WORD_W];
    evtDesc[6] = {15'd0, 1'b0, statCnt, evtFramelessBar, fragOut, errOut, evtPushReason};
    evtDesc[7] = {16'd0, idOut};

    markDesc[0] = '0;
    markDesc[1] = '0;
    markDesc[2] = '0;
    markDesc[3] = '0;
    markDesc[4] = markAddr[WORD_W-1:0];
    markDesc[5] = markAddr[ADDR_W-1:WORD_W];
    markDesc[6] = {15'd0, 1'b1, markCnt, 1'b0, {FRAG_W{1'b0}}, {ERR_W{1'b0}},
                   (markFlush ? PUSH_FLUSH : PUSH_ROUTE)};
    markDesc[7] = {16'd0, markIdOut};

    outData = descQ[stb.wordSel];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      descQ <= '0;
    end else if (stb.loadEvt) begin
      descQ <= evtDesc;
    end else if (stb.loadMark) begin
      descQ <= markDesc;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statCnt <= '0;
      curId   <= '0;
    end else begin
      if (ppduStart) begin
        statCnt <= statBufUsed ? CNT_W'(1) : '0;
        curId   <= ppduId;
      end else if (statBufUsed && statCnt != CNT_MAX) begin
        statCnt <= statCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      markCnt   <= '0;
      markId    <= '0;
      markAddr  <= '0;
      markFlush <= 1'b0;
    end else if (ppduEnd || ppduFlush) begin
      markCnt   <= statCnt;
      markId    <= curId;
      markAddr  <= endStatAddr;
      markFlush <= ppduFlush;
    end
  end
endmodule

// File: rtl/mon_desc_builder.sv
module mon_desc_builder
  import mdb_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           cfgEndMarkEn,
  input  logic           cfgCopyPpduId,
  input  logic           evtValid,
  output logic           evtReady,
  input  logic [127:0]   evtFrameInfo,
  input  logic [63:0]    evtStatAddr,
  input  logic [1:0]     evtPushReason,
  input  logic [4:0]     evtErrCode,
  input  logic [3:0]     evtFragNum,
  input  logic           evtFramelessBar,
  input  logic           statBufUsed,
  input  logic           ppduStart,
  input  logic [15:0]    ppduId,
  input  logic           ppduEnd,
  input  logic           ppduFlush,
  input  logic [63:0]    endStatAddr,
  output logic           outValid,
  input  logic           outReady,
  output logic [31:0]    outData,
  output logic           outLast,
  output logic           illegalPush
);
  mdb_strobe_t stb;

  mdb_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .cfgEndMarkEn  (cfgEndMarkEn),
    .evtValid      (evtValid),
    .evtPushReason (evtPushReason),
    .ppduEnd       (ppduEnd),
    .ppduFlush     (ppduFlush),
    .outReady      (outReady),
    .evtReady      (evtReady),
    .outValid      (outValid),
    .outLast       (outLast),
    .illegalPush   (illegalPush),
    .stb           (stb)
  );

  mdb_datapath u_dp (
    .clk             (clk),
    .rstN            (rstN),
    .cfgCopyPpduId   (cfgCopyPpduId),
    .evtFrameInfo    (evtFrameInfo),
    .evtStatAddr     (evtStatAddr),
    .evtPushReason   (evtPushReason),
    .evtErrCode      (evtErrCode),
    .evtFragNum      (evtFragNum),
    .evtFramelessBar (evtFramelessBar),
    .statBufUsed     (statBufUsed),
    .ppduStart       (ppduStart),
    .ppduId          (ppduId),
    .ppduEnd         (ppduEnd),
    .ppduFlush       (ppduFlush),
    .endStatAddr     (endStatAddr),
    .stb             (stb),
    .outData         (outData)
  );
endmodule

// File: rtl/mdb_checker.sv
module mdb_checker (
  input logic        clk,
  input logic        rstN,
  input logic        evtReady,
  input logic        outValid,
  input logic        outReady,
  input logic [31:0] outData,
  input logic        outLast
);
  logic [2:0] beatIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) beatIdx <= '0;
    else if (outValid && outReady) beatIdx <= beatIdx + 1'b1;
  end

  // R8: a stalled beat holds
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData));
  // R8: last flag only on the eighth beat
  a_r8_last_beat: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid && beatIdx == 3'd7);
  // R9: no acceptance while a descriptor is in flight
  a_r9_no_accept_busy: assert property (@(posedge clk) disable iff (!rstN)
    evtReady |-> !outValid);
  // R1: reserved top of word 6 is zero
  a_r1_word6_reserved: assert property (@(posedge clk) disable iff (!rstN)
    outValid && beatIdx == 3'd6 |-> outData[31:17] == 15'd0);
  // R2: upper half of word 7 left for the stamper
  a_r2_word7_upper: assert property (@(posedge clk) disable iff (!rstN)
    outValid && beatIdx == 3'd7 |-> outData[31:16] == 16'd0);
  // R3: illegal push code never leaves the block
  a_r3_no_bad_push: assert property (@(posedge clk) disable iff (!rstN)
    outValid && beatIdx == 3'd6 |-> outData[1:0] != 2'd3);
  // R4: error code only with an error push
  a_r4_err_zero: assert property (@(posedge clk) disable iff (!rstN)
    outValid && beatIdx == 3'd6 && outData[1:0] != 2'd0 |-> outData[6:2] == 5'd0);
  // R10: marker clears MPDU-level fields of word 6
  a_r10_marker_clear: assert property (@(posedge clk) disable iff (!rstN)
    outValid && beatIdx == 3'd6 && outData[16] |-> outData[11:7] == 5'd0);
endmodule

bind mon_desc_builder mdb_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .evtReady (evtReady),
  .outValid (outValid),
  .outReady (outReady),
  .outData  (outData),
  .outLast  (outLast)
);

// File: tb/sim_mon_desc_builder.sv
`timescale 1ns/1ps
module sim_mon_desc_builder;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cfgEndMarkEn = 1'b0;
  logic         cfgCopyPpduId = 1'b1;
  logic         evtValid = 1'b0;
  logic         evtReady;
  logic [127:0] evtFrameInfo = '0;
  logic [63:0]  evtStatAddr = '0;
  logic [1:0]   evtPushReason = '0;
  logic [4:0]   evtErrCode = '0;
  logic [3:0]   evtFragNum = '0;
  logic         evtFramelessBar = 1'b0;
  logic         statBufUsed = 1'b0;
  logic         ppduStart = 1'b0;
  logic [15:0]  ppduId = '0;
  logic         ppduEnd = 1'b0;
  logic         ppduFlush = 1'b0;
  logic [63:0]  endStatAddr = '0;
  logic         outValid;
  logic         outReady = 1'b1;
  logic [31:0]  outData;
  logic         outLast;
  logic         illegalPush;

  int total = 0;
  int bad = 0;
  logic [31:0] got [8];
  int gotCount;

  always #4 clk = ~clk;

  mon_desc_builder u0 (
    .clk(clk), .rstN(rstN), .cfgEndMarkEn(cfgEndMarkEn), .cfgCopyPpduId(cfgCopyPpduId),
    .evtValid(evtValid), .evtReady(evtReady), .evtFrameInfo(evtFrameInfo),
    .evtStatAddr(evtStatAddr), .evtPushReason(evtPushReason), .evtErrCode(evtErrCode),
    .evtFragNum(evtFragNum), .evtFramelessBar(evtFramelessBar), .statBufUsed(statBufUsed),
    .ppduStart(ppduStart), .ppduId(ppduId), .ppduEnd(ppduEnd), .ppduFlush(ppduFlush),
    .endStatAddr(endStatAddr), .outValid(outValid), .outReady(outReady),
    .outData(outData), .outLast(outLast), .illegalPush(illegalPush)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] w6(input logic [1:0] push, input logic [4:0] err,
      input logic [3:0] frag, input logic fl, input logic [3:0] cnt, input logic eop);
    return {15'd0, eop, cnt, fl, frag, err, push};
  endfunction

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic newPpdu(input logic [15:0] id, input int bufs);
    @(negedge clk); ppduStart = 1'b1; ppduId = id;
    @(negedge clk); ppduStart = 1'b0;
    for (int i = 0; i < bufs; i++) pulse(statBufUsed);
  endtask

  task automatic sendEvt(input logic [127:0] fw, input logic [63:0] addr,
      input logic [1:0] push, input logic [4:0] err, input logic [3:0] frag, input logic fl);
    @(negedge clk);
    check("R9 ready before event", {31'd0, evtReady}, 32'd1);
    evtValid = 1'b1; evtFrameInfo = fw; evtStatAddr = addr;
    evtPushReason = push; evtErrCode = err; evtFragNum = frag; evtFramelessBar = fl;
    @(negedge clk);
    evtValid = 1'b0;
  endtask

  // collects one descriptor; bp toggles ready and checks holding (R8)
  task automatic collect(input logic bp);
    logic [31:0] held;
    logic stalled;
    int waitCnt;
    gotCount = 0;
    stalled = 1'b0;
    held = '0;
    waitCnt = 0;
    outReady = !bp;
    while (gotCount < 8 && waitCnt < 100) begin
      if (outValid) begin
        if (stalled) check("R8 held beat", outData, held);
        if (outReady) begin
          got[gotCount] = outData;
          check("R8 last flag", {31'd0, outLast}, {31'd0, gotCount == 7});
          gotCount++;
        end
        stalled = outValid && !outReady;
        held = outData;
      end
      if (gotCount < 8 && gotCount > 0) check("R9 busy not ready", {31'd0, evtReady}, 32'd0);
      @(negedge clk);
      waitCnt++;
      if (bp) outReady = !outReady;
    end
    outReady = 1'b1;
    check("R8 eight beats", gotCount, 8);
  endtask

  task automatic quiet(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(req, {31'd0, outValid}, 32'd0);
    end
  endtask

  task automatic t_reset;
    check("R9 reset outValid", {31'd0, outValid}, 32'd0);
    check("R9 reset evtReady", {31'd0, evtReady}, 32'd1);
    check("R3 reset illegalPush", {31'd0, illegalPush}, 32'd0);
  endtask

  task automatic t_routing;
    logic [127:0] fw = {32'hDEAD_BEEF, 32'h0010_ABCD, 32'h1111_2222, 32'h3333_4444};
    newPpdu(16'h1234, 2);
    sendEvt(fw, 64'h0000_00AB_5566_7788, 2'd1, 5'd5, 4'd9, 1'b0);
    collect(1'b0);
    check("R7 word0", got[0], 32'h3333_4444);
    check("R7 word1", got[1], 32'h1111_2222);
    check("R7 word2", got[2], 32'h0010_ABCD);
    check("R7 word3", got[3], 32'hDEAD_BEEF);
    check("R7 word4", got[4], 32'h5566_7788);
    check("R7 word5", got[5], 32'h0000_00AB);
    check("R1 R4 R5 R11 word6", got[6], w6(2'd1, 5'd0, 4'd9, 1'b0, 4'd2, 1'b0));
    check("R2 R12 word7", got[7], 32'h0000_1234);
  endtask

  task automatic t_error;
    logic [127:0] fw = {32'h0, 32'h0000_0F00, 32'h0, 32'h0};
    sendEvt(fw, 64'h1, 2'd0, 5'd14, 4'd7, 1'b0);
    collect(1'b0);
    check("R4 R5 error push word6", got[6], w6(2'd0, 5'd14, 4'd0, 1'b0, 4'd2, 1'b0));
  endtask

  task automatic t_frameless;
    sendEvt({128{1'b1}}, 64'h2, 2'd1, 5'd0, 4'd6, 1'b1);
    collect(1'b0);
    check("R6 word0 cleared", got[0], 32'h0);
    check("R6 word1 cleared", got[1], 32'h0);
    check("R6 word2 masked", got[2], 32'h008F_FF00);
    check("R6 word3 kept", got[3], 32'hFFFF_FFFF);
    check("R6 R5 word6", got[6], w6(2'd1, 5'd0, 4'd0, 1'b1, 4'd2, 1'b0));
  endtask

  task automatic t_illegal;
    sendEvt({128{1'b1}}, 64'h3, 2'd3, 5'd1, 4'd1, 1'b0);
    check("R3 illegal pulse", {31'd0, illegalPush}, 32'd1);
    @(negedge clk);
    check("R3 pulse one cycle", {31'd0, illegalPush}, 32'd0);
    quiet(10, "R3 no descriptor");
  endtask

  task automatic t_markers;
    cfgEndMarkEn = 1'b1;
    newPpdu(16'h00A5, 3);
    @(negedge clk); endStatAddr = 64'h0000_0077_CAFE_0001; ppduEnd = 1'b1;
    @(negedge clk); ppduEnd = 1'b0;
    collect(1'b0);
    check("R10 end word0", got[0] | got[1] | got[2] | got[3], 32'h0);
    check("R10 end word4", got[4], 32'hCAFE_0001);
    check("R10 end word5", got[5], 32'h0000_0077);
    check("R10 end word6", got[6], w6(2'd1, 5'd0, 4'd0, 1'b0, 4'd3, 1'b1));
    check("R10 end word7", got[7], 32'h0000_00A5);
    newPpdu(16'h00B6, 1);
    @(negedge clk); endStatAddr = 64'h9; ppduFlush = 1'b1; ppduEnd = 1'b1;
    @(negedge clk); ppduFlush = 1'b0; ppduEnd = 1'b0;
    collect(1'b0);
    check("R10 flush word6", got[6], w6(2'd2, 5'd0, 4'd0, 1'b0, 4'd1, 1'b1));
    check("R10 flush word4", got[4], 32'h9);
    cfgEndMarkEn = 1'b0;
    pulse(ppduEnd);
    quiet(12, "R10 marker disabled");
  endtask

  task automatic t_saturate;
    newPpdu(16'h0042, 20);
    sendEvt('0, 64'h0, 2'd2, 5'd3, 4'd0, 1'b0);
    collect(1'b0);
    check("R11 saturate at 15", got[6], w6(2'd2, 5'd0, 4'd0, 1'b0, 4'd15, 1'b0));
    newPpdu(16'h0043, 0);
    cfgCopyPpduId = 1'b0;
    sendEvt('0, 64'h0, 2'd1, 5'd0, 4'd0, 1'b0);
    collect(1'b1);
    check("R11 cleared by start", got[6], w6(2'd1, 5'd0, 4'd0, 1'b0, 4'd0, 1'b0));
    check("R12 id not copied", got[7], 32'h0);
    cfgCopyPpduId = 1'b1;
  endtask

  task automatic t_backpressure;
    logic [127:0] fw = {32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111};
    newPpdu(16'hBEEF, 0);
    sendEvt(fw, 64'h6666_6666_5555_5555, 2'd1, 5'd0, 4'd0, 1'b0);
    collect(1'b1);
    check("R8 stall word0", got[0], 32'h1111_1111);
    check("R8 stall word3", got[3], 32'h4444_4444);
    check("R8 stall word5", got[5], 32'h6666_6666);
    check("R12 stall word7", got[7], 32'h0000_BEEF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_routing();
    t_error();
    t_frameless();
    t_illegal();
    t_markers();
    t_saturate();
    t_backpressure();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule